// File: doc/BRIEF.md
# Clock-Generator Configuration Register File with Two-Wire Block Access

This block is a two-wire serial slave that holds the configuration of a clock generator in eight byte-wide registers. Six are writable; two return fixed identification bytes. The bus lines arrive already synchronized to the system clock. The block pulls the data line low through an open-drain enable, `sda_oe_o`; the pad and the pull-up sit outside it. The stored fields drive parallel outputs: a six-bit frequency code, the source select, a tristate-everything flag, the spread-spectrum controls and the per-output clock enables.

Transfers use block framing. A write carries an address byte, then a command byte and a count byte, and both of these are acknowledged and dropped. The data bytes that follow fill the registers from index 0 upward. A read sends a count byte first and then every register in index order. Index 1 reports the live levels of three frequency-strap pins in its top bits, not stored data.

Top module: `clkcfg_twi_regs`

## Requirements
- R1: An address byte whose upper seven bits equal parameter `SLAVE_ADDR` (default 0x69) is acknowledged. Any other address gets no acknowledge, and the block leaves SDA released until the next START, so later bytes go unacknowledged.
- R2: In a write, the two bytes after the address byte (command and count) are acknowledged and change no register.
- R3: Write data bytes land in register 0, 1, 2 and onward in order, and each is acknowledged. Register 2 drives `sdram_en_o`, register 3 drives `pci_en_o` and register 4 drives `misc_en_o`, bit for bit.
- R4: After reset the registers hold 0x00, 0x1C, 0xFF, 0xFF, 0xFF, 0x90 for indices 0 to 5, and the outputs show those values. SDA is released.
- R5: Register 0 field layout: bits 7:4 are code bits 3:0, bit 2 is code bit 4, bit 1 is code bit 5, bit 3 is the source select (1 = software code) and bit 0 is tristate-all (1 = outputs off).
- R6: Register 1 stores bits 4:0. Bits 4:2 drive `fixed_en_o`, bit 1 selects the narrow ±0.25% depth (0 = ±0.5%) and bit 0 enables spread spectrum. On read, bits 7:5 return `strap_i[2:0]` live, and writes to those bits are ignored.
- R7: Register 5: bits 7:5 are the three-bit skew code, bit 4 enables the free-running memory clock, and bits 3:0 are stored and read back.
- R8: Reads of registers 6 and 7 return 0x98 and 0x21. Writes to them are acknowledged and have no effect.
- R9: A read returns the count value 8 first, then registers 0 to 7 in order, then 0xFF for every further byte.
- R10: When the master does not acknowledge a read byte, the block releases SDA and keeps it released until the next START.
- R11: Write bytes beyond register 7 are acknowledged and discarded.
- R12: A STOP or repeated START at any bit position returns the protocol engine to idle. Registers already written keep their values, and a partially shifted byte is dropped.
- R13: The block starts pulling SDA low only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | Synchronized serial clock level |
| sda_i | input | 1 | Synchronized serial data level (bus value) |
| sda_oe_o | output | 1 | 1 = pull SDA low |
| strap_i | input | 3 | Live frequency-strap pin levels, read back in register 1 bits 7:5 |
| sel_code_o | output | 6 | Software frequency code |
| sw_sel_o | output | 1 | 1 = software code selects frequency, 0 = strap pins |
| tristate_o | output | 1 | 1 = all clock outputs tristated |
| ss_en_o | output | 1 | Spread spectrum enable |
| ss_narrow_o | output | 1 | 1 = ±0.25% depth, 0 = ±0.5% |
| fixed_en_o | output | 3 | Enables of the fixed-frequency outputs |
| sdram_en_o | output | 8 | Memory clock enables |
| pci_en_o | output | 8 | Bus clock enables |
| misc_en_o | output | 8 | Auxiliary clock enables |
| skew_o | output | 3 | Memory-to-processor skew code |
| sdram_free_o | output | 1 | Free-running memory clock enable |

## Verification
The hardest case to reach is a transfer cut short mid-byte. A STOP or repeated START must land after some bits of a data byte have shifted in but before its acknowledge slot, and this must leave earlier registers intact. The bench drives bits one at a time, so it can stop after four bits, or restart after three, and then read the registers back. The exhaustive address sweep also covers every non-matching address, each followed by a further byte that must stay unacknowledged.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;
  localparam int unsigned NUM_REGS  = 8;
  localparam int unsigned NUM_RW    = 6;
  localparam int unsigned REG_AW    = $clog2(NUM_REGS);
  localparam int unsigned HDR_BYTES = 2;
  localparam int unsigned STRAP_REG = 1;

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_WRITE, S_READ, S_IGNORE
  } twi_state_t;

  function automatic logic [7:0] reg_default(input int unsigned idx);
    case (idx)
      0:       return 8'h00;
      1:       return 8'h1C;
      5:       return 8'h90;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic [7:0] reg_wmask(input int unsigned idx);
    return (idx == STRAP_REG) ? 8'h1F : 8'hFF;
  endfunction
endpackage

// File: rtl/clkcfg_edge.sv
module clkcfg_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise  = scl_i & ~scl_q;
  assign scl_fall  = ~scl_i & scl_q;
  assign start_det = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_det  = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/clkcfg_fsm.sv
module clkcfg_fsm
  import clkcfg_pkg::*;
#(
  parameter logic [6:0]  SLAVE_ADDR = 7'h69,
  parameter int unsigned IDX_W      = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_i,
  input  logic              scl_i,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [7:0]        rd_byte,
  output logic [IDX_W-1:0]  rd_sel,
  output logic              wr_en,
  output logic [REG_AW-1:0] wr_idx,
  output logic [7:0]        wr_data,
  output logic              sda_oe
);
  localparam logic [IDX_W-1:0] IDX_MAX = '1;
  localparam logic [IDX_W-1:0] IDX_LO  = IDX_W'(HDR_BYTES);
  localparam logic [IDX_W-1:0] IDX_HI  = IDX_W'(HDR_BYTES + NUM_REGS);

  twi_state_t       state_q, state_d;
  logic [3:0]       bitcnt_q, bitcnt_d;
  logic [7:0]       shreg_q, shreg_d;
  logic             ack_q, ack_d, mack_q, mack_d, nack_q, nack_d;
  logic             load_q, load_d, rw_q, rw_d, oe_q, oe_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             in_range;

  assign in_range = (idx_q >= IDX_LO) && (idx_q < IDX_HI);
  assign wr_idx   = REG_AW'(idx_q - IDX_LO);
  assign wr_data  = shreg_q;
  assign rd_sel   = idx_q;
  assign sda_oe   = oe_q;

  always_comb begin
    state_d  = state_q;  bitcnt_d = bitcnt_q; shreg_d = shreg_q;
    ack_d    = ack_q;    mack_d   = mack_q;   nack_d  = nack_q;
    load_d   = load_q;   rw_d     = rw_q;     oe_d    = oe_q;
    idx_d    = idx_q;    wr_en    = 1'b0;
    if (stop_det) begin
      state_d = S_IDLE; oe_d = 1'b0; ack_d = 1'b0; mack_d = 1'b0; load_d = 1'b0;
    end else if (start_det) begin
      state_d = S_ADDR; oe_d = 1'b0; ack_d = 1'b0; mack_d = 1'b0; load_d = 1'b0;
      bitcnt_d = 4'd0; idx_d = '0;
    end else begin
      case (state_q)
        S_ADDR, S_WRITE: begin
          if (ack_q) begin
            if (scl_fall) begin
              ack_d = 1'b0; oe_d = 1'b0; bitcnt_d = 4'd0;
              if (state_q == S_ADDR) begin
                idx_d = '0;
                if (rw_q) begin
                  state_d = S_READ; load_d = 1'b1;
                end else begin
                  state_d = S_WRITE;
                end
              end else if (idx_q != IDX_MAX) begin
                idx_d = idx_q + 1'b1;
              end
            end
          end else if (scl_rise && bitcnt_q != 4'd8) begin
            shreg_d  = {shreg_q[6:0], sda_i};
            bitcnt_d = bitcnt_q + 4'd1;
          end else if (scl_fall && bitcnt_q == 4'd8) begin
            if (state_q == S_ADDR) begin
              if (shreg_q[7:1] == SLAVE_ADDR) begin
                ack_d = 1'b1; oe_d = 1'b1; rw_d = shreg_q[0];
              end else begin
                state_d = S_IGNORE;
              end
            end else begin
              ack_d = 1'b1; oe_d = 1'b1; wr_en = in_range;
            end
          end
        end
        S_READ: begin
          if (load_q) begin
            load_d = 1'b0; shreg_d = rd_byte; oe_d = ~rd_byte[7]; bitcnt_d = 4'd0;
          end else if (mack_q) begin
            if (scl_rise) begin
              nack_d = sda_i;
            end else if (scl_fall) begin
              mack_d = 1'b0;
              if (nack_q) begin
                state_d = S_IGNORE;
              end else begin
                load_d = 1'b1;
                if (idx_q != IDX_MAX) idx_d = idx_q + 1'b1;
              end
            end
          end else if (scl_fall) begin
            if (bitcnt_q == 4'd7) begin
              oe_d = 1'b0; mack_d = 1'b1;
            end else begin
              shreg_d  = {shreg_q[6:0], 1'b0};
              oe_d     = ~shreg_q[6];
              bitcnt_d = bitcnt_q + 4'd1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE; bitcnt_q <= 4'd0; shreg_q <= 8'h00;
      ack_q   <= 1'b0;   mack_q   <= 1'b0; nack_q  <= 1'b0;
      load_q  <= 1'b0;   rw_q     <= 1'b0; oe_q    <= 1'b0;
      idx_q   <= '0;
    end else begin
      state_q <= state_d; bitcnt_q <= bitcnt_d; shreg_q <= shreg_d;
      ack_q   <= ack_d;   mack_q   <= mack_d;   nack_q  <= nack_d;
      load_q  <= load_d;  rw_q     <= rw_d;     oe_q    <= oe_d;
      idx_q   <= idx_d;
    end
  end

  // R13: the pull-down is engaged only during the low phase of SCL
  a_r13_oe_rises_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_q) |-> !scl_i);
  // R12: a STOP always lands in idle with SDA released
  a_r12_stop_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (state_q == S_IDLE) && !oe_q);
  // R1: an ignored transfer never drives the bus
  a_r1_ignore_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_IGNORE) |-> !oe_q);
  // R10: master NACK ends the read
  a_r10_nack_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_READ && mack_q && nack_q && scl_fall && !start_det && !stop_det)
      |=> (state_q == S_IGNORE) && !oe_q);
endmodule

// File: rtl/clkcfg_regfile.sv
module clkcfg_regfile
  import clkcfg_pkg::*;
#(
  parameter int unsigned IDX_W = 4,
  parameter logic [7:0]  ID_HI = 8'h98,
  parameter logic [7:0]  ID_LO = 8'h21
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [REG_AW-1:0]        wr_idx,
  input  logic [7:0]               wr_data,
  input  logic [IDX_W-1:0]         rd_sel,
  input  logic [2:0]               strap_i,
  output logic [7:0]               rd_byte,
  output logic [NUM_RW-1:0][7:0]   cfg_o
);
  logic [NUM_RW-1:0][7:0] regs_q, view;
  logic [NUM_RW-1:0]      we;

  for (genvar g = 0; g < NUM_RW; g++) begin : g_we
    assign we[g] = wr_en && (wr_idx == REG_AW'(g));
    // R3: a write strobe lands the masked byte in its own register
    a_r3_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      we[g] |=> regs_q[g] == ($past(wr_data) & reg_wmask(g)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NUM_RW; k++) regs_q[k] <= reg_default(k);
    end else begin
      for (int k = 0; k < NUM_RW; k++)
        if (we[k]) regs_q[k] <= wr_data & reg_wmask(k);
    end
  end

  always_comb begin
    view = regs_q;
    view[STRAP_REG][7:5] = strap_i;
  end

  always_comb begin
    rd_byte = 8'hFF;
    if (rd_sel == '0) rd_byte = 8'(NUM_REGS);
    for (int k = 0; k < NUM_RW; k++)
      if (rd_sel == IDX_W'(k + 1)) rd_byte = view[k];
    if (rd_sel == IDX_W'(NUM_RW + 1)) rd_byte = ID_HI;
    if (rd_sel == IDX_W'(NUM_RW + 2)) rd_byte = ID_LO;
  end

  assign cfg_o = regs_q;

  // R8: strobes aimed at the identification slots leave storage untouched
  a_r8_ro_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx >= REG_AW'(NUM_RW)) |=> $stable(regs_q));
endmodule

// File: rtl/clkcfg_twi_regs.sv
module clkcfg_twi_regs
  import clkcfg_pkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR = 7'h69,
  parameter logic [7:0] ID_HI      = 8'h98,
  parameter logic [7:0] ID_LO      = 8'h21
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  input  logic [2:0] strap_i,
  output logic [5:0] sel_code_o,
  output logic       sw_sel_o,
  output logic       tristate_o,
  output logic       ss_en_o,
  output logic       ss_narrow_o,
  output logic [2:0] fixed_en_o,
  output logic [7:0] sdram_en_o,
  output logic [7:0] pci_en_o,
  output logic [7:0] misc_en_o,
  output logic [2:0] skew_o,
  output logic       sdram_free_o
);
  localparam int unsigned IDX_W = $clog2(HDR_BYTES + NUM_REGS + 1) + 1;

  logic [1:0]             rsync_q;
  logic                   rst_sn;
  logic                   scl_rise, scl_fall, start_det, stop_det;
  logic                   wr_en;
  logic [REG_AW-1:0]      wr_idx;
  logic [7:0]             wr_data, rd_byte;
  logic [IDX_W-1:0]       rd_sel;
  logic [NUM_RW-1:0][7:0] cfg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_sn = rsync_q[1];

  clkcfg_edge u_edge (
    .clk(clk), .rst_n(rst_sn), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  clkcfg_fsm #(.SLAVE_ADDR(SLAVE_ADDR), .IDX_W(IDX_W)) u_fsm (
    .clk(clk), .rst_n(rst_sn), .sda_i(sda_i), .scl_i(scl_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det),
    .rd_byte(rd_byte), .rd_sel(rd_sel),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .sda_oe(sda_oe_o)
  );

  clkcfg_regfile #(.IDX_W(IDX_W), .ID_HI(ID_HI), .ID_LO(ID_LO)) u_regs (
    .clk(clk), .rst_n(rst_sn), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_sel(rd_sel), .strap_i(strap_i),
    .rd_byte(rd_byte), .cfg_o(cfg)
  );

  assign sel_code_o   = {cfg[0][1], cfg[0][2], cfg[0][7:4]};
  assign sw_sel_o     = cfg[0][3];
  assign tristate_o   = cfg[0][0];
  assign fixed_en_o   = cfg[1][4:2];
  assign ss_narrow_o  = cfg[1][1];
  assign ss_en_o      = cfg[1][0];
  assign sdram_en_o   = cfg[2];
  assign pci_en_o     = cfg[3];
  assign misc_en_o    = cfg[4];
  assign skew_o       = cfg[5][7:5];
  assign sdram_free_o = cfg[5][4];
endmodule

// File: tb/clkcfg_twi_regs_test.sv
module clkcfg_twi_regs_test;
  localparam int H = 6;
  localparam logic [6:0] DEV = 7'h69;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, scl_m, sda_m;
  logic [2:0] strap;
  logic sda_oe;
  logic [5:0] sel_code; logic sw_sel, tri_o, ss_en, ss_nar, sfree;
  logic [2:0] fixed_en, skew;
  logic [7:0] sdram_en, pci_en, misc_en;
  logic sda_bus;
  assign sda_bus = sda_m & ~sda_oe;

  clkcfg_twi_regs uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe_o(sda_oe),
    .strap_i(strap), .sel_code_o(sel_code), .sw_sel_o(sw_sel), .tristate_o(tri_o),
    .ss_en_o(ss_en), .ss_narrow_o(ss_nar), .fixed_en_o(fixed_en),
    .sdram_en_o(sdram_en), .pci_en_o(pci_en), .misc_en_o(misc_en),
    .skew_o(skew), .sdram_free_o(sfree)
  );

  int checks = 0, fails = 0, r13_bad = 0;
  logic done = 1'b0;
  logic oe_prev = 1'b0;
  logic [7:0] model [6];

  always @(posedge clk) begin
    if (rst_n && sda_oe && !oe_prev && scl_m) r13_bad++;
    oe_prev <= sda_oe;
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] wmask(input int k);
    return (k == 1) ? 8'h1F : 8'hFF;
  endfunction

  function automatic logic [7:0] exp_rd(input int k);
    if (k == 0) return 8'd8;
    if (k == 2) return {strap, model[1][4:0]};
    if (k >= 1 && k <= 6) return model[k-1];
    if (k == 7) return 8'h98;
    if (k == 8) return 8'h21;
    return 8'hFF;
  endfunction

  task automatic check_outputs(input string pfx);
    chk({pfx, " R5 reg0 fields"}, {58'd0, sel_code, sw_sel, tri_o},
        {58'd0, model[0][1], model[0][2], model[0][7:4], model[0][3], model[0][0]});
    chk({pfx, " R6 reg1 fields"}, {59'd0, fixed_en, ss_nar, ss_en}, {59'd0, model[1][4:0]});
    chk({pfx, " R3 enable regs"}, {40'd0, sdram_en, pci_en, misc_en},
        {40'd0, model[2], model[3], model[4]});
    chk({pfx, " R7 reg5 fields"}, {60'd0, skew, sfree}, {60'd0, model[5][7:4]});
  endtask

  task automatic t_start;
    sda_m = 1'b1; tick(H); scl_m = 1'b1; tick(H); sda_m = 1'b0; tick(H); scl_m = 1'b0; tick(H);
  endtask

  task automatic t_stop;
    sda_m = 1'b0; tick(H); scl_m = 1'b1; tick(H); sda_m = 1'b1; tick(H);
  endtask

  task automatic t_bit(input logic b);
    sda_m = b; tick(H); scl_m = 1'b1; tick(H); scl_m = 1'b0;
  endtask

  task automatic write_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) t_bit(b[i]);
    sda_m = 1'b1; tick(H); scl_m = 1'b1; tick(H/2);
    ack = ~sda_bus;
    tick(H - H/2); scl_m = 1'b0;
  endtask

  task automatic read_byte(input logic nack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(H); scl_m = 1'b1; tick(H/2); b[i] = sda_bus; tick(H - H/2); scl_m = 1'b0;
    end
    sda_m = nack; tick(H); scl_m = 1'b1; tick(H); scl_m = 1'b0; tick(1); sda_m = 1'b1;
  endtask

  task automatic wr_txn(input logic [7:0] cmd, input logic [7:0] cnt, input int n,
                        input logic [7:0] d [12], output logic [15:0] acks);
    logic a;
    acks = '0;
    t_start;
    write_byte({DEV, 1'b0}, a); acks[0] = a;
    write_byte(cmd, a);         acks[1] = a;
    write_byte(cnt, a);         acks[2] = a;
    for (int k = 0; k < n; k++) begin write_byte(d[k], a); acks[3+k] = a; end
    t_stop;
  endtask

  task automatic rd_txn(input int n, output logic [7:0] r [12]);
    logic a;
    for (int k = 0; k < 12; k++) r[k] = 8'h00;
    t_start;
    write_byte({DEV, 1'b1}, a);
    chk("R9 read address ack", {63'd0, a}, 64'd1);
    for (int k = 0; k < n; k++) read_byte(k == n - 1, r[k]);
    t_stop;
  endtask

  task automatic readback_all(input string tag);
    logic [7:0] r [12];
    rd_txn(10, r);
    for (int k = 0; k < 10; k++) chk(tag, {56'd0, r[k]}, {56'd0, exp_rd(k)});
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d [12];
    logic [7:0] r [12];
    logic [15:0] acks;
    logic a, a2;
    logic [7:0] rb;

    scl_m = 1'b1; sda_m = 1'b1; strap = 3'b101; rst_n = 1'b0;
    for (int k = 0; k < 6; k++) model[k] = 8'h00;
    model[1] = 8'h1C; model[2] = 8'hFF; model[3] = 8'hFF; model[4] = 8'hFF; model[5] = 8'h90;
    tick(5); rst_n = 1'b1; tick(8);

    // R4: reset state
    chk("R4 sda released", {63'd0, sda_oe}, 64'd0);
    chk("R4 reset outputs",
        {23'd0, sel_code, sw_sel, tri_o, fixed_en, ss_nar, ss_en, sdram_en, pci_en, misc_en, skew, sfree},
        {23'd0, 6'd0, 1'b0, 1'b0, 3'b111, 1'b0, 1'b0, 8'hFF, 8'hFF, 8'hFF, 3'b100, 1'b1});
    check_outputs("R4");

    // R9: read defaults, including IDs and bytes past the end
    readback_all("R9 default read");

    // R1: sweep every address
    for (int ad = 0; ad < 128; ad++) begin
      t_start;
      write_byte({7'(ad), 1'b0}, a);
      chk("R1 address ack", {63'd0, a}, {63'd0, (7'(ad) == DEV)});
      if (7'(ad) != DEV) begin
        write_byte(8'h00, a2);
        chk("R1 ignored until START", {63'd0, a2}, 64'd0);
      end
      t_stop;
    end
    check_outputs("R1 no side effect");

    // R2 R3 R8 R11: block writes with several patterns
    for (int p = 0; p < 4; p++) begin
      strap = 3'(p * 3 + 2);
      for (int k = 0; k < 12; k++) d[k] = 8'(p * 91 + k * 39 + 17);
      wr_txn(8'(p * 13 + 1), 8'(p * 7 + 3), 10, d, acks);
      chk("R2 header bytes acked", {62'd0, acks[2:1]}, 64'd3);
      chk("R3 data bytes acked", {58'd0, acks[8:3]}, 64'h3F);
      chk("R8 id writes acked", {62'd0, acks[10:9]}, 64'd3);
      chk("R11 overflow writes acked", {62'd0, acks[12:11]}, 64'd3);
      for (int k = 0; k < 6; k++) model[k] = d[k] & wmask(k);
      check_outputs("R3 pattern");
      readback_all("R8 R11 readback");
    end

    // R6: strap readback sweep
    for (int s = 0; s < 8; s++) begin
      strap = 3'(s);
      rd_txn(3, r);
      chk("R6 strap readback", {56'd0, r[2]}, {56'd0, 3'(s), model[1][4:0]});
    end

    // R10: NACK releases the bus until next START
    t_start;
    write_byte({DEV, 1'b1}, a);
    read_byte(1'b1, rb);
    chk("R10 count byte", {56'd0, rb}, 64'd8);
    read_byte(1'b1, rb);
    chk("R10 bus released after NACK", {56'd0, rb}, 64'hFF);
    t_stop;
    rd_txn(1, r);
    chk("R10 recovery read", {56'd0, r[0]}, 64'd8);

    // R12: STOP mid-byte keeps finished register, drops partial one
    t_start;
    write_byte({DEV, 1'b0}, a); write_byte(8'h00, a); write_byte(8'h00, a);
    write_byte(8'hA6, a);
    for (int i = 7; i >= 4; i--) t_bit(i[0]);
    t_stop;
    model[0] = 8'hA6;
    check_outputs("R12 stop mid-byte");
    readback_all("R12 stop readback");

    // R12: repeated START mid-byte
    t_start;
    write_byte({DEV, 1'b0}, a); write_byte(8'h00, a); write_byte(8'h00, a);
    for (int i = 0; i < 3; i++) t_bit(1'b0);
    t_start;
    write_byte({DEV, 1'b0}, a);
    chk("R12 restart address ack", {63'd0, a}, 64'd1);
    write_byte(8'h55, a); write_byte(8'h01, a); write_byte(8'h3B, a);
    chk("R12 restart data ack", {63'd0, a}, 64'd1);
    t_stop;
    model[0] = 8'h3B;
    check_outputs("R12 restart");
    readback_all("R12 restart readback");

    // R13: bus pulled low only during SCL low
    chk("R13 drive starts with SCL low", r13_bad, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule